// File: doc/BRIEF.md
# Single-Precision Reciprocal Square Root Unit

This block takes one 32-bit single-precision operand and returns an approximation of one over its square root. The approximation is bit-exact to a particular fixed-point vector engine. A one-cycle `start` pulse hands the operand to the unit. After a fixed number of cycles a one-cycle `done` pulse marks the result on `dout`, and `dout` keeps that value until the next completion.

Operands that need special handling are settled in a single cycle and return fixed, non-standard encodings: infinities, NaNs, zeros, subnormals and negatives. Every other operand goes through a fixed-point Newton refinement. The refinement uses only multiplications, and they are issued one at a time on a single shared multiplier. That multiplier rounds in an unusual way: when any discarded bit is set, it adds a fixed bias before truncating. A leading-zero count then normalises the refined value, and the unit packs it into an IEEE-754 word whose two lowest bits are forced to zero.

Top module: `rsqrt_unit`

## Requirements
- R1: An operand of exactly 0x7F800000 (positive infinity) yields 0x00000000.
- R2: An operand with exponent field (bits 30:23) equal to 0xFF and a nonzero fraction (bits 22:0) yields its bit 31 OR'd with 0x7F800001.
- R3: An operand whose exponent field is zero (a zero or a subnormal of either sign) yields its bit 31 OR'd with 0x7F800000.
- R4: Every other operand with bit 31 set, negative infinity included, yields 0xFF800001.
- R5: For the operands of R1 to R4, `done` is high in the cycle after the one in which `start` is sampled.
- R6: The fixed-point multiply forms the full product of two 32-bit values, adds 0x01437000 when any of the product's low 23 bits is set, and keeps bits 54:23 of the sum.
- R7: For a positive normal operand, let k be the unbiased exponent and p = k & 1. The unit starts from seed 0x00800000 >> p, half term (0x800000 | fraction) >> (1+p) and exponent -(k >>> 1). It then runs six rounds of: s = mul(z,z); c = 0x00C00000 - mul(half,s); z = mul(z,c).
- R8: After the rounds, the unit computes t = clz32(z) - 8 + p and lowers the exponent by t. If t < 1, z is shifted right by -t; otherwise it is shifted left by t. z is then shifted right by p. The result is ((exponent+127) << 23) | (z & 0x7FFFFF) with bits 1:0 cleared. Such a result is positive, for example 1.0 -> 0x3F800000 and 4.0 -> 0x3F000000.
- R9: For a positive normal operand, `done` rises exactly 20 cycles after the cycle in which `start` is sampled (one load cycle, three multiply cycles per round, one pack cycle), and `done` is high for one cycle only.
- R10: A `start` pulse that arrives while a computation is in flight is ignored: it changes neither the result nor the completion timing.
- R11: While `rst_n` is low, `done` is 0 and `dout` is 0x00000000.
- R12: `dout` changes only in a cycle where `done` is high, and it holds its value after that until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operand-valid pulse; accepted only while idle |
| din | input | 32 | Single-precision operand |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 32 | Reciprocal square root result |

## Verification
The bench covers every special-case branch on both signs:
- It feeds negative infinity, which a design testing the sign before the infinity check would still get right but a design matching only the exact positive-infinity pattern by magnitude would return as zero.
- It feeds negative NaNs, where dropping the sign would give 0x7F800001.
- It feeds subnormals with a nonzero fraction, which a design that checks only for an all-zero magnitude would push into the iteration.

Odd and even exponents are both covered, including the extreme normals 0x00800000 and 0x7F7FFFFF. A mistake in the parity handling of the seed, of the half term or of the final right shift would therefore show up as a wrong exponent or a doubled mantissa. Random operands are compared with a behavioural model that includes the biased rounding, so a multiplier that leaves out or misplaces the 0x01437000 bias drifts in the low fraction bits. A second `start` is injected in the middle of a computation, to catch a design that restarts or emits an extra `done`.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int          FRAC_W     = 23;
  localparam int          EXP_BIAS   = 127;
  localparam logic [31:0] POS_INF    = 32'h7F80_0000;
  localparam logic [31:0] NAN_CODE   = 32'h7F80_0001;
  localparam logic [31:0] NEG_CODE   = 32'hFF80_0001;
  localparam logic [31:0] ONE_FIX    = 32'h0080_0000;
  localparam logic [31:0] THREE_HALF = 32'h00C0_0000;
  localparam logic [31:0] ROUND_BIAS = 32'h0143_7000;
  localparam logic [31:0] FRAC_KEEP  = 32'h007F_FFFC;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ZSQ,
    S_HZ,
    S_ZC,
    S_PACK
  } state_e;

  typedef struct packed {
    logic        hit;
    logic [31:0] val;
  } special_t;

  // Decode the operands that bypass the iteration; priority order matters.
  function automatic special_t classify(input logic [31:0] x);
    special_t r;
    r.hit = 1'b1;
    r.val = '0;
    if (x == POS_INF) begin
      r.val = '0;
    end else if (x[30:23] == 8'hFF && x[22:0] != '0) begin
      r.val = {x[31], 31'b0} | NAN_CODE;
    end else if (x[30:23] == 8'h00) begin
      r.val = {x[31], 31'b0} | POS_INF;
    end else if (x[31]) begin
      r.val = NEG_CODE;
    end else begin
      r.hit = 1'b0;
    end
    return r;
  endfunction

  // Count of zeros above the highest set bit; 32 for an all-zero word.
  function automatic logic [5:0] lead_zeros(input logic [31:0] v);
    logic [5:0] n;
    n = 6'd32;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = 6'(31 - i);
    end
    return n;
  endfunction

endpackage

// File: rtl/rsqrt_special.sv
module rsqrt_special
  import rsqrt_pkg::*;
(
  input  logic [31:0] x,
  output logic        hit,
  output logic [31:0] val
);

  special_t cls;

  always_comb begin
    cls = classify(x);
    hit = cls.hit;
    val = cls.val;
  end

endmodule

// File: rtl/rsqrt_fixmul.sv
module rsqrt_fixmul #(
  parameter int          MW    = 32,
  parameter int          FRAC  = 23,
  parameter logic [31:0] BIAS  = 32'h0143_7000
) (
  input  logic [MW-1:0] a,
  input  logic [MW-1:0] b,
  output logic [MW-1:0] p,
  output logic          round_up
);

  localparam int PW = 2 * MW;

  logic [PW-1:0] full;
  logic [PW-1:0] adj;

  always_comb begin
    full     = PW'(a) * PW'(b);
    round_up = |full[FRAC-1:0];
    adj      = round_up ? (full + PW'(BIAS)) : full;
    p        = MW'(adj >> FRAC);
  end

endmodule

// File: rtl/rsqrt_norm.sv
module rsqrt_norm
  import rsqrt_pkg::*;
(
  input  logic [31:0]       z,
  input  logic              par,
  input  logic signed [9:0] e,
  output logic [31:0]       res
);

  logic [5:0]  lz;
  int          sh;
  int          ex;
  logic [31:0] zs;
  logic [31:0] ef;

  always_comb begin
    lz = lead_zeros(z);
    sh = int'(lz) - 8 + int'(par);
    ex = int'(e) - sh;
    if (sh < 1) zs = z >> (-sh);
    else        zs = z << sh;
    zs  = zs >> par;
    ef  = 32'(ex + EXP_BIAS);
    res = (ef << FRAC_W) | (zs & FRAC_KEEP);
  end

endmodule

// File: rtl/rsqrt_unit.sv
module rsqrt_unit
  import rsqrt_pkg::*;
#(
  parameter int ITERS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] din,
  output logic        done,
  output logic [31:0] dout
);

  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;

  state_e            state_q;
  logic [31:0]       z_q;
  logic [31:0]       half_q;
  logic [31:0]       t_q;
  logic signed [9:0] exp_q;
  logic              par_q;
  logic [IW-1:0]     iter_q;

  // Named internal events for the checker.
  logic idle;
  logic pack_fire;
  logic special_hit;
  logic last_iter;

  logic [31:0]       special_val;
  logic signed [9:0] k_s;
  logic signed [9:0] exp_init;
  logic              par_in;
  logic [31:0]       mant;
  logic [31:0]       z_init;
  logic [31:0]       half_init;
  logic [31:0]       mul_a;
  logic [31:0]       mul_b;
  logic [31:0]       mul_p;
  logic              mul_rnd;
  logic [31:0]       packed_val;

  assign idle      = (state_q == S_IDLE);
  assign pack_fire = (state_q == S_PACK);
  assign last_iter = (iter_q == IW'(ITERS - 1));

  rsqrt_special u_special (
    .x   (din),
    .hit (special_hit),
    .val (special_val)
  );

  // Initial values for the refinement.
  always_comb begin
    k_s       = $signed({2'b00, din[30:23]}) - 10'sd127;
    par_in    = k_s[0];
    exp_init  = -(k_s >>> 1);
    mant      = {8'b0, 1'b1, din[22:0]};
    z_init    = par_in ? (ONE_FIX >> 1) : ONE_FIX;
    half_init = par_in ? (mant >> 2) : (mant >> 1);
  end

  // Operand selection for the single shared multiplier.
  always_comb begin
    unique case (state_q)
      S_ZSQ:   begin mul_a = z_q;    mul_b = z_q; end
      S_HZ:    begin mul_a = half_q; mul_b = t_q; end
      S_ZC:    begin mul_a = z_q;    mul_b = t_q; end
      default: begin mul_a = '0;     mul_b = '0;  end
    endcase
  end

  rsqrt_fixmul #(
    .MW   (32),
    .FRAC (FRAC_W),
    .BIAS (ROUND_BIAS)
  ) u_mul (
    .a        (mul_a),
    .b        (mul_b),
    .p        (mul_p),
    .round_up (mul_rnd)
  );

  rsqrt_norm u_norm (
    .z   (z_q),
    .par (par_q),
    .e   (exp_q),
    .res (packed_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      z_q     <= '0;
      half_q  <= '0;
      t_q     <= '0;
      exp_q   <= '0;
      par_q   <= 1'b0;
      iter_q  <= '0;
      done    <= 1'b0;
      dout    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            if (special_hit) begin
              dout <= special_val;
              done <= 1'b1;
            end else begin
              z_q     <= z_init;
              half_q  <= half_init;
              exp_q   <= exp_init;
              par_q   <= par_in;
              iter_q  <= '0;
              state_q <= S_ZSQ;
            end
          end
        end
        S_ZSQ: begin
          t_q     <= mul_p;
          state_q <= S_HZ;
        end
        S_HZ: begin
          t_q     <= THREE_HALF - mul_p;
          state_q <= S_ZC;
        end
        S_ZC: begin
          z_q <= mul_p;
          if (last_iter) begin
            state_q <= S_PACK;
          end else begin
            iter_q  <= iter_q + IW'(1);
            state_q <= S_ZSQ;
          end
        end
        S_PACK: begin
          dout    <= packed_val;
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // The rounding flag is an observation point only.
  logic rnd_seen_unused;
  assign rnd_seen_unused = mul_rnd;

endmodule

// File: rtl/rsqrt_unit_chk.sv
module rsqrt_unit_chk #(
  parameter int ITERS = 6,
  parameter int IW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   din,
  input logic          done,
  input logic [31:0]   dout,
  input logic          idle,
  input logic          special_hit,
  input logic          pack_fire,
  input logic [IW-1:0] iter_q,
  input logic [31:0]   z_q
);

  AST_INF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && din == 32'h7F80_0000) |=> (done && dout == 32'h0)); // R1

  AST_NAN_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && din[30:23] == 8'hFF && din[22:0] != 23'h0)
    |=> (done && dout == ({$past(din[31]), 31'b0} | 32'h7F80_0001))); // R2

  AST_ZERO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && din[30:23] == 8'h00)
    |=> (done && dout == {$past(din[31]), 31'h7F80_0000})); // R3

  AST_NEG_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && din[31] && din[30:23] != 8'h00 &&
     !(din[30:23] == 8'hFF && din[22:0] != 23'h0))
    |=> (done && dout == 32'hFF80_0001)); // R4

  AST_SPECIAL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && special_hit) |=> done); // R5

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (int'(iter_q) <= ITERS - 1)); // R7

  AST_Z_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pack_fire |-> (z_q != 32'h0)); // R8

  AST_PACK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    pack_fire |=> (done && dout[1:0] == 2'b00 && !dout[31])); // R8

  AST_NORMAL_NOEARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && !special_hit) |=> !done); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R9

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !pack_fire) |=> !done); // R10

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout)); // R12

endmodule

bind rsqrt_unit rsqrt_unit_chk #(
  .ITERS (ITERS),
  .IW    (IW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .din         (din),
  .done        (done),
  .dout        (dout),
  .idle        (idle),
  .special_hit (special_hit),
  .pack_fire   (pack_fire),
  .iter_q      (iter_q),
  .z_q         (z_q)
);

// File: tb/tb_rsqrt_unit.sv
module tb_rsqrt_unit;

  localparam int NORM_LAT = 3 * 6 + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] din = '0;
  logic        done;
  logic [31:0] dout;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  rsqrt_unit dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .din   (din),
    .done  (done),
    .dout  (dout)
  );

  // Biased fixed-point product, restated with integer division.
  function automatic longint unsigned fmul(input longint unsigned a, input longint unsigned b);
    longint unsigned m;
    m = a * b;
    if ((m % 64'd8388608) != 0) m = m + 64'd21196800;
    return (m / 64'd8388608) % 64'd4294967296;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x, output bit sp);
    int e, k, p, ek, sh, cnt;
    longint unsigned z, half, c;
    logic [31:0] r;
    e  = int'(x[30:23]);
    sp = 1'b1;
    if (x == 32'h7F80_0000) return 32'h0;
    if (e == 255 && x[22:0] != 0) return {x[31], 31'h7F80_0001};
    if (e == 0) return {x[31], 31'h7F80_0000};
    if (x[31]) return 32'hFF80_0001;
    sp   = 1'b0;
    k    = e - 127;
    p    = k & 1;
    ek   = -(k >>> 1);
    z    = (p == 1) ? 64'd4194304 : 64'd8388608;
    half = (64'd8388608 + longint'(x[22:0])) >> (1 + p);
    for (int i = 0; i < 6; i++) begin
      c = (64'd12582912 - fmul(half, fmul(z, z))) % 64'd4294967296;
      z = fmul(z, c);
    end
    cnt = 0;
    while (cnt < 32 && z[31 - cnt] == 1'b0) cnt++;
    sh = cnt - 8 + p;
    if (sh < 1) z = z >> (-sh);
    else        z = (z << sh) % 64'd4294967296;
    ek = ek - sh;
    z  = z >> p;
    r  = 32'((ek + 127) * 8388608) | 32'(z % 64'd8388608);
    r[1:0] = 2'b00;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Issue one operand, compare done and dout on every clock until quiet.
  task automatic run_op(input string vtag, input logic [31:0] x,
                        input bit poke, input logic [31:0] alt);
    logic [31:0] expv;
    bit          sp;
    int          lat;
    string       ttag;
    expv = model(x, sp);
    lat  = sp ? 1 : NORM_LAT;
    ttag = sp ? "R5" : "R9";
    din   = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= lat + 2; c++) begin
      check(poke ? "R10" : ttag, {31'b0, done}, {31'b0, (c == lat)});
      if (c == lat) check(poke ? "R10" : vtag, dout, expv);
      if (c > lat)  check("R12", dout, expv);
      if (poke && c == 4) begin
        start = 1'b1;
        din   = alt;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9: got no completion expected end of run within cycle limit");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", {31'b0, done}, 32'h0);
    check("R11", dout, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Special encodings.
    run_op("R1", 32'h7F80_0000, 1'b0, 0);
    run_op("R2", 32'h7FC0_0000, 1'b0, 0);
    run_op("R2", 32'hFFC0_1234, 1'b0, 0);
    run_op("R2", 32'h7F80_0001, 1'b0, 0);
    run_op("R3", 32'h0000_0000, 1'b0, 0);
    run_op("R3", 32'h8000_0000, 1'b0, 0);
    run_op("R3", 32'h0000_0001, 1'b0, 0);
    run_op("R3", 32'h807F_FFFF, 1'b0, 0);
    run_op("R4", 32'hBF80_0000, 1'b0, 0);
    run_op("R4", 32'hFF80_0000, 1'b0, 0);
    run_op("R4", 32'h8080_0000, 1'b0, 0);

    // Exact values for the iteration and packing.
    run_op("R7", 32'h3F80_0000, 1'b0, 0);
    check("R8", dout, 32'h3F80_0000);
    run_op("R7", 32'h4080_0000, 1'b0, 0);
    check("R8", dout, 32'h3F00_0000);
    run_op("R7", 32'h3E80_0000, 1'b0, 0);
    check("R8", dout, 32'h4000_0000);

    // Odd exponents and extreme normals.
    run_op("R8", 32'h4000_0000, 1'b0, 0);
    run_op("R8", 32'h3F00_0000, 1'b0, 0);
    run_op("R8", 32'h0080_0000, 1'b0, 0);
    run_op("R8", 32'h7F7F_FFFF, 1'b0, 0);
    run_op("R6", 32'h4049_0FDB, 1'b0, 0);

    // A second start while busy is dropped.
    run_op("R10", 32'h4140_0000, 1'b1, 32'h7F80_0000);
    run_op("R10", 32'h3DCC_CCCD, 1'b1, 32'h4080_0000);

    // Random positive normals.
    for (int i = 0; i < 200; i++) begin
      logic [7:0] ee;
      ee = 8'($urandom_range(1, 254));
      run_op("R6", {1'b0, ee, 23'($urandom)}, 1'b0, 0);
    end

    // Fully random words, specials included.
    for (int i = 0; i < 100; i++) begin
      run_op("R7", $urandom, 1'b0, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule